// File: doc/BRIEF.md
# Reference-Timer Oscillator Trim Controller

This block measures an on-chip clock against an independent reference and nudges a 6-bit trim code one step at a time to keep that clock on frequency. Two tick counters run side by side. One counts pulses of the clock under test and the other counts pulses of the reference. Each measurement window closes when the reference count reaches a programmed terminal count. At that point the count of the clock under test is captured and compared with an expected value. The trim code then moves down when the clock is fast, up when it is slow beyond a tolerance, and stays put otherwise.

Both tick inputs are single-cycle enables sampled on the system clock. The block does not model how the trim code acts on the oscillator; it only produces the code. Each time a window closes it pulses an update strobe and shows the direction it chose. The enable input freezes the whole measurement without losing the partial window.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset `trim` is 32 (mid-scale), `upd` is 0 and `dir` is 2'b00 (hold).
- R2: While `en` is 1, every cycle with `int_tick` high adds one to the internal count, and every cycle with `ref_tick` high adds one to the reference count. Both counts start at zero after reset.
- R3: A window closes in a cycle where `en` and `ref_tick` are both high and the reference count including that tick is at least `ref_term`, so a `ref_term` of 0 or 1 closes a window on every reference tick. `upd` is high for exactly the one cycle after that clock edge, and is low otherwise.
- R4: The captured count includes an `int_tick` in the closing cycle. After the closing edge both counts restart from zero.
- R5: If the captured count is greater than `exp_count`, `dir` becomes 2'b10 (down) and `trim` decreases by one.
- R6: If the captured count plus `tol` is less than `exp_count`, `dir` becomes 2'b01 (up) and `trim` increases by one.
- R7: Otherwise `dir` becomes 2'b00 (hold) and `trim` is unchanged, and `upd` still pulses.
- R8: `trim` saturates at 0 on a down step and at 63 on an up step. It never wraps, and `upd` and `dir` still report the decision.
- R9: While `en` is 0, ticks on either input are ignored, no window closes and `trim` holds. The partial counts resume when `en` returns to 1.
- R10: `trim` changes only at the edge that raises `upd`, and by at most one.
- R11: `dir` never takes the code 2'b11, and it keeps the last decision until the next window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Measurement enable; 0 freezes counts and trim |
| int_tick | input | 1 | One pulse per tick of the clock under test |
| ref_tick | input | 1 | One pulse per tick of the reference |
| exp_count | input | 16 | Expected internal count per window |
| ref_term | input | 16 | Reference ticks per window |
| tol | input | 16 | Allowed shortfall below `exp_count` |
| trim | output | 6 | Trim code |
| upd | output | 1 | One-cycle strobe when a window closes |
| dir | output | 2 | Last decision: 00 hold, 01 up, 10 down |

## Verification
The decision is tried with captured counts on both sides of the expected value and on each edge of the tolerance band: exactly expected, expected plus one, expected minus the tolerance, and one below that. This separates a strict from a non-strict compare at each boundary. A closing cycle that carries an internal tick, followed by a second window of the same length, shows whether the coincident tick is captured and whether both counts restart. Long runs of down steps and of up steps check saturation. A window interrupted by a disabled stretch full of ticks on both inputs checks that those ticks are ignored and that the partial counts are kept. A terminal count of zero checks per-tick windows.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
   typedef enum logic [1:0] {
      TDIR_HOLD = 2'b00,
      TDIR_UP   = 2'b01,
      TDIR_DOWN = 2'b10
   } tdir_e;
endpackage

// File: rtl/osc_tick_counter.sv
module osc_tick_counter #(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic         clr,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_plus
);
   localparam logic [W-1:0] MAXV = '1;

   // count including the tick of the current cycle
   generate
      if (SAT) begin : g_sat
         assign cnt_plus = (tick && (cnt != MAXV)) ? cnt + W'(1) : cnt;
      end else begin : g_wrap
         assign cnt_plus = tick ? cnt + W'(1) : cnt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt_plus;
   end
endmodule

// File: rtl/osc_trim_decide.sv
module osc_trim_decide
   import osc_trim_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] cap,
   input  logic [W-1:0] expv,
   input  logic [W-1:0] tol,
   output tdir_e        dir
);
   logic [W:0] lo_sum;
   assign lo_sum = {1'b0, cap} + {1'b0, tol};

   always_comb begin
      if (cap > expv)              dir = TDIR_DOWN;
      else if (lo_sum < {1'b0, expv}) dir = TDIR_UP;
      else                         dir = TDIR_HOLD;
   end
endmodule

// File: rtl/osc_trim_reg.sv
module osc_trim_reg
   import osc_trim_pkg::*;
#(
   parameter int             W   = 6,
   parameter logic [W-1:0]   RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  tdir_e        dir,
   output logic [W-1:0] trim
);
   localparam logic [W-1:0] MAXT = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim <= RST;
      end else if (step) begin
         case (dir)
            TDIR_UP:   if (trim != MAXT) trim <= trim + W'(1);
            TDIR_DOWN: if (trim != '0)   trim <= trim - W'(1);
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
   import osc_trim_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int REF_W  = 16,
   parameter int TRIM_W = 6,
   parameter bit INT_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              int_tick,
   input  logic              ref_tick,
   input  logic [CNT_W-1:0]  exp_count,
   input  logic [REF_W-1:0]  ref_term,
   input  logic [CNT_W-1:0]  tol,
   output logic [TRIM_W-1:0] trim,
   output logic              upd,
   output logic [1:0]        dir
);
   localparam logic [TRIM_W-1:0] TRIM_MID = {1'b1, {(TRIM_W-1){1'b0}}};

   generate
      if (TRIM_W < 2 || TRIM_W > 16) begin : g_bad_trim_w
         $error("osc_trim_ctrl: TRIM_W out of range");
      end
      if (CNT_W < 2 || REF_W < 2) begin : g_bad_cnt_w
         $error("osc_trim_ctrl: counter width too small");
      end
   endgenerate

   logic [CNT_W-1:0] int_cnt, int_plus;
   logic [REF_W-1:0] ref_cnt, ref_plus;
   logic             win_end;
   tdir_e            dec_dir;
   tdir_e            dir_q;

   assign win_end = en && ref_tick && (ref_plus >= ref_term);

   osc_tick_counter #(.W(CNT_W), .SAT(INT_SAT)) u_int_cnt (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(int_tick), .clr(win_end),
      .cnt(int_cnt), .cnt_plus(int_plus)
   );

   osc_tick_counter #(.W(REF_W), .SAT(1'b1)) u_ref_cnt (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(ref_tick), .clr(win_end),
      .cnt(ref_cnt), .cnt_plus(ref_plus)
   );

   osc_trim_decide #(.W(CNT_W)) u_decide (
      .cap(int_plus), .expv(exp_count), .tol(tol), .dir(dec_dir)
   );

   osc_trim_reg #(.W(TRIM_W), .RST(TRIM_MID)) u_trim (
      .clk(clk), .rst_n(rst_n), .step(win_end), .dir(dec_dir), .trim(trim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd   <= 1'b0;
         dir_q <= TDIR_HOLD;
      end else begin
         upd <= win_end;
         if (win_end) dir_q <= dec_dir;
      end
   end

   assign dir = dir_q;

   // int_cnt and ref_cnt feed the decision only through cnt_plus
   logic unused_cnt;
   assign unused_cnt = ^{int_cnt, ref_cnt};
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
   parameter int TRIM_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              ref_tick,
   input logic              upd,
   input logic [1:0]        dir,
   input logic [TRIM_W-1:0] trim
);
   localparam logic [TRIM_W-1:0] TMAX = '1;

   a_r10_trim_only_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |-> $stable(trim));

   a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && dir == 2'b10) |->
         (($past(trim) == '0) ? (trim == '0) : (trim == $past(trim) - TRIM_W'(1))));

   a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && dir == 2'b01) |->
         (($past(trim) == TMAX) ? (trim == TMAX) : (trim == $past(trim) + TRIM_W'(1))));

   a_r7_hold_keeps_trim: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && dir == 2'b00) |-> $stable(trim));

   a_r3_upd_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> $past(en && ref_tick));

   a_r9_no_upd_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !upd);

   a_r11_dir_legal: assert property (@(posedge clk) disable iff (!rst_n)
      dir != 2'b11);

   a_r11_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |-> $stable(dir));
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(.TRIM_W(TRIM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .ref_tick(ref_tick),
   .upd(upd), .dir(dir), .trim(trim)
);

// File: tb/osc_trim_ctrl_tb.sv
module osc_trim_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        int_tick = 1'b0;
   logic        ref_tick = 1'b0;
   logic [15:0] exp_count = '0;
   logic [15:0] ref_term = '0;
   logic [15:0] tol = '0;
   logic [5:0]  trim;
   logic        upd;
   logic [1:0]  dir;

   int checks = 0;
   int errors = 0;
   int m_trim = 32;
   int m_exp = 0;
   int m_tol = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   osc_trim_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .int_tick(int_tick), .ref_tick(ref_tick),
      .exp_count(exp_count), .ref_term(ref_term), .tol(tol),
      .trim(trim), .upd(upd), .dir(dir)
   );

   task automatic chk(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic set_cfg(int e, int t, int term);
      @(negedge clk);
      exp_count = 16'(e); tol = 16'(t); ref_term = 16'(term);
      m_exp = e; m_tol = t;
   endtask

   // pre: internal ticks already counted in this window
   task automatic do_window(string req, int pre, int ints, int refs, bit co);
      int cap;
      int d;
      cap = pre + ints + int'(co);
      if (cap > m_exp) d = 2;
      else if (cap + m_tol < m_exp) d = 1;
      else d = 0;
      if (d == 2 && m_trim > 0) m_trim--;
      if (d == 1 && m_trim < 63) m_trim++;
      for (int i = 0; i < ints; i++) begin
         @(negedge clk); int_tick = 1'b1; ref_tick = 1'b0;
      end
      for (int j = 0; j < refs; j++) begin
         @(negedge clk);
         chk({req, " R3 no early upd"}, int'(upd), 0);
         int_tick = (j == refs - 1) && co; ref_tick = 1'b1;
      end
      @(negedge clk); int_tick = 1'b0; ref_tick = 1'b0;
      chk({req, " R3 upd"}, int'(upd), 1);
      chk({req, " dir"}, int'(dir), d);
      chk({req, " trim"}, int'(trim), m_trim);
      @(negedge clk);
      chk({req, " R3 single pulse"}, int'(upd), 0);
      chk({req, " R11 dir held"}, int'(dir), d);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 trim", int'(trim), 32);
      chk("R1 upd", int'(upd), 0);
      chk("R1 dir", int'(dir), 0);
      rst_n = 1'b1; en = 1'b1;
      m_trim = 32;
   endtask

   task automatic t_band;
      set_cfg(100, 4, 5);
      do_window("R5 fast", 0, 110, 5, 1'b0);
      do_window("R6 slow", 0, 90, 5, 1'b0);
      do_window("R7 low edge", 0, 96, 5, 1'b0);
      do_window("R6 below band", 0, 95, 5, 1'b0);
      do_window("R7 exact", 0, 100, 5, 1'b0);
      do_window("R5 one over", 0, 101, 5, 1'b0);
   endtask

   task automatic t_coincide;
      set_cfg(10, 0, 2);
      do_window("R4 coincident tick", 0, 9, 2, 1'b1);
      do_window("R4 counts restart", 0, 10, 2, 1'b0);
      do_window("R2 count", 0, 3, 2, 1'b0);
   endtask

   task automatic t_enable;
      int t0;
      set_cfg(12, 0, 3);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); int_tick = 1'b1; ref_tick = 1'b0;
      end
      @(negedge clk); en = 1'b0; int_tick = 1'b1; ref_tick = 1'b1;
      t0 = int'(trim);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk("R9 no upd while disabled", int'(upd), 0);
      end
      chk("R9 trim held", int'(trim), t0);
      en = 1'b1; int_tick = 1'b0; ref_tick = 1'b0;
      do_window("R9 resume", 6, 6, 3, 1'b0);
   endtask

   task automatic t_term_zero;
      set_cfg(4, 1, 0);
      do_window("R3 term zero", 0, 6, 1, 1'b0);
      do_window("R3 term zero again", 0, 2, 1, 1'b0);
      set_cfg(4, 1, 1);
      do_window("R3 term one", 0, 4, 1, 1'b0);
   endtask

   task automatic t_sat_low;
      set_cfg(10, 1, 2);
      while (m_trim > 0) do_window("R5 walk down", 0, 12, 2, 1'b0);
      do_window("R8 floor", 0, 12, 2, 1'b0);
      chk("R8 floor value", int'(trim), 0);
   endtask

   task automatic t_sat_high;
      set_cfg(10, 1, 2);
      while (m_trim < 63) do_window("R6 walk up", 0, 5, 2, 1'b0);
      do_window("R8 ceiling", 0, 5, 2, 1'b0);
      chk("R8 ceiling value", int'(trim), 63);
   endtask

   initial begin
      t_reset();
      t_band();
      t_coincide();
      t_enable();
      t_term_zero();
      t_sat_low();
      t_sat_high();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule